// File: doc/BRIEF.md
# Virtual Supervisor Interrupt Enable and Pending Registers

This block holds two 64-bit machine-level registers: a virtual-interrupt enable mask and a virtual pending vector. It also computes the pending vector that supervisor mode sees. Machine software can raise a supervisor interrupt without delegating that cause. It sets the enable bit for the cause, then sets the matching virtual pending bit, and the bit appears in the supervisor view. When the delegation bit for a cause is set, the hardware pending bit for that cause is passed through unchanged.

The block sits beside the CSR file. Each cycle it receives a CSR address, a write strobe and write data, together with the delegation mask and the hardware pending vector. It returns registered readback data, a decode hit flag and the registered supervisor pending vector.

The writable, read-only-zero and read-only-one behaviour of each bit is set by parameter masks. With a 32-bit data path, the upper halves of both registers are reached through their own alias addresses.

Top module: `vsint_regs`

## Requirements
- R1: The enable register decodes at CSR address 0x308 and the pending register at 0x305. With XLEN=32, their bits 63:32 decode at 0x318 (enable) and 0x319 (pending). A decoded address raises `rd_ok`.
- R2: After a synchronous reset, every writable bit of both registers is 0, and every read-only-one enable bit reads 1. With the default masks, 0x308, 0x305 and 0x319 read 0x00000000, and 0x318 reads 0xFF000000.
- R3: Bits 0, 2–4, 6–8 and 10–12 of both registers always read 0, and writes to them are ignored. With the default masks, writing all ones to 0x305 reads back 0xFFFFE222.
- R4: Enable bit 5 is writable only when parameter `MIP5_WR` is 1; otherwise it reads 0. The default is 0, so writing 0x00000020 to 0x308 leaves bit 5 clear.
- R5: Enable bits 1, 9 and 13–63 are writable where `EN_WR_MASK` is 1. Bits 13–63 that are not writable read 1 where `EN_RO1_MASK` is 1 and 0 elsewhere. With the default masks, writing all ones to 0x308 reads back 0x0FFFE202, and writing zero to 0x318 reads back 0xFF000000.
- R6: A write to one 32-bit half leaves the other half of the same register unchanged.
- R7: Supervisor pending bit i equals `hw_pend[i]` when `deleg_mask[i]` is 1. Otherwise it equals virtual pending bit i if enable bit i is 1, and 0 if not.
- R8: A write changes the registers at the clock edge where `csr_wr` is sampled high. `rd_data`, `rd_ok` and `s_pend` are registered and reflect the register state and inputs sampled at the preceding edge.
- R9: An address outside the map returns `rd_ok`=0 and `rd_data`=0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe for the addressed register |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| deleg_mask | input | 64 | Per-cause delegation mask |
| hw_pend | input | 64 | Hardware pending vector |
| s_pend | output | 64 | Registered supervisor-visible pending vector |
| rd_data | output | XLEN | Registered readback of the addressed register |
| rd_ok | output | 1 | Registered address-decode hit |

## Verification
The assertions check the selection rule of the supervisor view on every cycle:
- A delegated bit must follow the hardware pending bit.
- A bit that is neither delegated nor enabled must stay 0.

They also check, on every cycle:
- Reserved low bits and read-only-one bits keep their fixed values.
- A miss reads as zero.
- A low-half write leaves the high half untouched.

Only the bench scenarios show the exact values that result from the default writability masks, the reset values and the virtual-pending alias on bits 1, 5 and 9.

// File: rtl/vsint_pkg.sv
package vsint_pkg;
  localparam logic [11:0] ADDR_EN_LO = 12'h308;
  localparam logic [11:0] ADDR_VP_LO = 12'h305;
  localparam logic [11:0] ADDR_EN_HI = 12'h318;
  localparam logic [11:0] ADDR_VP_HI = 12'h319;

  // bits that may ever hold state: 1, 5, 9 and 13..63
  localparam logic [63:0] LEGAL_MASK = 64'hFFFF_FFFF_FFFF_E222;
  localparam logic [63:0] UPPER_MASK = 64'hFFFF_FFFF_FFFF_E000;
  localparam logic [63:0] BIT5_MASK  = 64'h0000_0000_0000_0020;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_LO,
    SEL_EN_HI,
    SEL_VP_LO,
    SEL_VP_HI
  } vsint_sel_e;
endpackage

// File: rtl/vsint_decode.sv
module vsint_decode
  import vsint_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [11:0] addr,
  output vsint_sel_e  sel
);
  localparam bit HAS_HI = (XLEN == 32);

  always_comb begin
    sel = SEL_NONE;
    case (addr)
      ADDR_EN_LO: sel = SEL_EN_LO;
      ADDR_VP_LO: sel = SEL_VP_LO;
      ADDR_EN_HI: sel = HAS_HI ? SEL_EN_HI : SEL_NONE;
      ADDR_VP_HI: sel = HAS_HI ? SEL_VP_HI : SEL_NONE;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/vsint_warl_reg.sv
module vsint_warl_reg #(
  parameter int          XLEN     = 32,
  parameter logic [63:0] WR_MASK  = '0,
  parameter logic [63:0] RO1_MASK = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [XLEN-1:0] wdata,
  output logic [63:0]     q
);
  logic [63:0] wide;
  logic [63:0] lane;
  logic [63:0] wmask;

  generate
    if (XLEN == 64) begin : g_full
      assign wide = wdata;
      assign lane = {64{wr_lo}};
      logic unused_hi;
      assign unused_hi = wr_hi;
    end else begin : g_split
      assign wide = {wdata, wdata};
      assign lane = {{32{wr_hi}}, {32{wr_lo}}};
    end
  endgenerate

  assign wmask = WR_MASK & lane;

  always_ff @(posedge clk) begin
    if (rst) q <= RO1_MASK;
    else     q <= (((q & ~wmask) | (wide & wmask)) & WR_MASK) | RO1_MASK;
  end
endmodule

// File: rtl/vsint_view.sv
module vsint_view (
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] deleg,
  input  logic [63:0] hw,
  input  logic [63:0] en,
  input  logic [63:0] vp,
  output logic [63:0] s_pend
);
  logic [63:0] nxt;

  always_comb begin
    for (int i = 0; i < 64; i++) begin
      if (deleg[i])   nxt[i] = hw[i];
      else if (en[i]) nxt[i] = vp[i];
      else            nxt[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) s_pend <= '0;
    else     s_pend <= nxt;
  end
endmodule

// File: rtl/vsint_regs.sv
module vsint_regs
  import vsint_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter logic [63:0] EN_WR_MASK  = 64'h00FF_FFFF_0FFF_E222,
  parameter logic [63:0] EN_RO1_MASK = 64'hFF00_0000_0000_0000,
  parameter logic [63:0] VP_WR_MASK  = 64'hFFFF_FFFF_FFFF_FFFF,
  parameter bit          MIP5_WR     = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_wr,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic [63:0]     deleg_mask,
  input  logic [63:0]     hw_pend,
  output logic [63:0]     s_pend,
  output logic [XLEN-1:0] rd_data,
  output logic            rd_ok
);
  localparam logic [63:0] EN_WR_EFF  = EN_WR_MASK & LEGAL_MASK & (MIP5_WR ? ~64'h0 : ~BIT5_MASK);
  localparam logic [63:0] EN_RO1_EFF = EN_RO1_MASK & UPPER_MASK & ~EN_WR_EFF;
  localparam logic [63:0] VP_WR_EFF  = VP_WR_MASK & LEGAL_MASK;

  vsint_sel_e  sel;
  logic [63:0] en_q;
  logic [63:0] vp_q;

  vsint_decode #(.XLEN(XLEN)) u_dec (
    .addr (csr_addr),
    .sel  (sel)
  );

  vsint_warl_reg #(.XLEN(XLEN), .WR_MASK(EN_WR_EFF), .RO1_MASK(EN_RO1_EFF)) u_en (
    .clk   (clk),
    .rst   (rst),
    .wr_lo (csr_wr && sel == SEL_EN_LO),
    .wr_hi (csr_wr && sel == SEL_EN_HI),
    .wdata (csr_wdata),
    .q     (en_q)
  );

  vsint_warl_reg #(.XLEN(XLEN), .WR_MASK(VP_WR_EFF), .RO1_MASK(64'h0)) u_vp (
    .clk   (clk),
    .rst   (rst),
    .wr_lo (csr_wr && sel == SEL_VP_LO),
    .wr_hi (csr_wr && sel == SEL_VP_HI),
    .wdata (csr_wdata),
    .q     (vp_q)
  );

  vsint_view u_view (
    .clk    (clk),
    .rst    (rst),
    .deleg  (deleg_mask),
    .hw     (hw_pend),
    .en     (en_q),
    .vp     (vp_q),
    .s_pend (s_pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_ok   <= 1'b0;
    end else begin
      rd_ok <= (sel != SEL_NONE);
      case (sel)
        SEL_EN_LO: rd_data <= en_q[XLEN-1:0];
        SEL_VP_LO: rd_data <= vp_q[XLEN-1:0];
        SEL_EN_HI: rd_data <= XLEN'(en_q[63:32]);
        SEL_VP_HI: rd_data <= XLEN'(vp_q[63:32]);
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vsint_regs_chk.sv
module vsint_regs_chk #(
  parameter int          XLEN   = 32,
  parameter logic [63:0] RO1    = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            csr_wr,
  input logic [11:0]     csr_addr,
  input logic [63:0]     deleg_mask,
  input logic [63:0]     hw_pend,
  input logic [63:0]     s_pend,
  input logic [XLEN-1:0] rd_data,
  input logic            rd_ok,
  input logic [63:0]     en_q,
  input logic [63:0]     vp_q
);
  localparam logic [63:0] RSV_LOW = 64'h0000_0000_0000_1DDD;

  // R7
  deleg_follows_hw_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((s_pend ^ $past(hw_pend)) & $past(deleg_mask)) == 64'h0));

  // R7
  hidden_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((s_pend & ~$past(deleg_mask) & ~$past(en_q)) == 64'h0));

  // R3
  reserved_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_q | vp_q) & RSV_LOW) == 64'h0);

  // R5
  ro1_held_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q & RO1) == RO1);

  // R9
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_ok |-> (rd_data == '0));

  // R6
  lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (XLEN == 32 && !$past(rst) && $past(csr_wr) && $past(csr_addr) == 12'h308)
      |-> (en_q[63:32] == $past(en_q[63:32])));
endmodule

bind vsint_regs vsint_regs_chk #(.XLEN(XLEN), .RO1(EN_RO1_EFF)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .csr_wr     (csr_wr),
  .csr_addr   (csr_addr),
  .deleg_mask (deleg_mask),
  .hw_pend    (hw_pend),
  .s_pend     (s_pend),
  .rd_data    (rd_data),
  .rd_ok      (rd_ok),
  .en_q       (en_q),
  .vp_q       (vp_q)
);

// File: tb/vsint_regs_test.sv
module vsint_regs_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] vp;
    logic [31:0] dl;
    logic [31:0] hw;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0FFF_E202},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678},
    '{32'h0000_0200, 32'h0000_0200, 32'h0000_0000, 32'h0000_0000, 32'h0000_0200},
    '{32'h0000_0020, 32'h0000_0020, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    '{32'hFFFF_FFFF, 32'h0000_F000, 32'h0000_8000, 32'h0000_0000, 32'h0000_6000},
    '{32'h0000_0002, 32'h0000_0002, 32'h0000_0002, 32'h0000_0000, 32'h0000_0000},
    '{32'h0000_0002, 32'h0000_0002, 32'h0000_0000, 32'h0000_0002, 32'h0000_0002}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [63:0] deleg_mask = '0;
  logic [63:0] hw_pend = '0;
  logic [63:0] s_pend;
  logic [31:0] rd_data;
  logic        rd_ok;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vsint_regs uut (
    .clk        (clk),
    .rst        (rst),
    .csr_wr     (csr_wr),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .deleg_mask (deleg_mask),
    .hw_pend    (hw_pend),
    .s_pend     (s_pend),
    .rd_data    (rd_data),
    .rd_ok      (rd_ok)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic ok, input logic [31:0] exp);
    @(negedge clk);
    csr_addr = a;
    @(negedge clk);
    check(req, {31'h0, rd_ok, rd_data}, {31'h0, ok, exp});
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 R2: reset values and decode
    rd_check("R2 en_lo reset", 12'h308, 1'b1, 32'h0000_0000);
    rd_check("R2 en_hi reset", 12'h318, 1'b1, 32'hFF00_0000);
    rd_check("R2 vp_lo reset", 12'h305, 1'b1, 32'h0000_0000);
    rd_check("R1 vp_hi reset", 12'h319, 1'b1, 32'h0000_0000);
    check("R2 s_pend reset", s_pend, 64'h0);

    // R7 R8: view table
    foreach (VECS[k]) begin
      wr(12'h308, VECS[k].en);
      wr(12'h305, VECS[k].vp);
      deleg_mask = {32'h0, VECS[k].dl};
      hw_pend    = {32'h0, VECS[k].hw};
      @(negedge clk);
      @(negedge clk);
      check($sformatf("R7 vector %0d", k), s_pend, {32'h0, VECS[k].exp});
    end
    deleg_mask = '0;
    hw_pend = '0;

    // R4: enable bit 5 read-only zero by default
    wr(12'h308, 32'h0000_0020);
    rd_check("R4 en bit5", 12'h308, 1'b1, 32'h0000_0000);
    // R5 R3: writable bits of enable low half
    wr(12'h308, 32'hFFFF_FFFF);
    rd_check("R5 en_lo ones", 12'h308, 1'b1, 32'h0FFF_E202);
    wr(12'h305, 32'hFFFF_FFFF);
    rd_check("R3 vp_lo ones", 12'h305, 1'b1, 32'hFFFF_E222);
    // R5: read-only-one upper bits
    wr(12'h318, 32'h0000_0000);
    rd_check("R5 en_hi zero", 12'h318, 1'b1, 32'hFF00_0000);
    wr(12'h318, 32'hFFFF_FFFF);
    rd_check("R5 en_hi ones", 12'h318, 1'b1, 32'hFFFF_FFFF);
    // R6: half independence
    wr(12'h308, 32'h0000_0000);
    rd_check("R6 en_hi kept", 12'h318, 1'b1, 32'hFFFF_FFFF);
    wr(12'h319, 32'hFFFF_FFFF);
    wr(12'h305, 32'h0000_0000);
    rd_check("R6 vp_hi kept", 12'h319, 1'b1, 32'hFFFF_FFFF);
    // R7: upper half visible through enable
    @(negedge clk);
    check("R7 upper view", s_pend, 64'hFFFF_FFFF_0000_0000);
    // R7: delegation of upper half overrides virtual bits
    deleg_mask = 64'hFFFF_0000_0000_0000;
    hw_pend    = 64'h0F00_0000_0000_0000;
    @(negedge clk);
    @(negedge clk);
    check("R7 upper deleg", s_pend, 64'h0F00_FFFF_0000_0000);
    deleg_mask = '0;
    hw_pend = '0;

    // R9: unknown address
    wr(12'h306, 32'hFFFF_FFFF);
    rd_check("R9 miss read", 12'h306, 1'b0, 32'h0000_0000);
    rd_check("R9 miss no write", 12'h308, 1'b1, 32'h0000_0000);

    // R8: readback registered one cycle after address
    @(negedge clk);
    csr_addr = 12'h319;
    #1;
    check("R8 rd before edge", {31'h0, rd_ok, rd_data}, {31'h0, 1'b1, 32'h0000_0000});
    @(negedge clk);
    check("R8 rd after edge", {32'h0, rd_data}, {32'h0, 32'hFFFF_FFFF});

    // R2: reset in mid-run restores reset values
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    rd_check("R2 en_hi after rst", 12'h318, 1'b1, 32'hFF00_0000);
    rd_check("R2 vp_hi after rst", 12'h319, 1'b1, 32'h0000_0000);

    finish_run();
  end
endmodule